// File: doc/BRIEF.md
# Two-Cycle Signed/Unsigned Fractional Multiplier

This unit multiplies two 8-bit operands and returns a 16-bit product together with a zero flag and a carry flag. A 3-bit mode selects how the operands are read: both unsigned, both signed, or the first signed and the second unsigned. A fourth bit of the mode picks integer or fractional form. In fractional form the product is shifted left by one place, so two Q1.7 inputs give a Q1.15 result. The product is always meant for one fixed register pair. The unit reports that pair as two constant index outputs, and the surrounding writeback logic uses them no matter which registers supplied the operands.

An operation starts with a single-cycle start strobe while the unit is idle. The unit holds busy for one cycle and then pulses done for one cycle, with the product and the flags valid at that moment. The product and the flags keep their values until the next operation completes. Instruction decode and register-file writeback are handled outside this block.

Top module: `frac_mul_unit`

## Requirements
- R1: Mode encoding: `mode_i[2]` = 1 selects fractional form. `mode_i[1:0]` selects signedness: 2'b00 both unsigned, 2'b01 both signed (two's complement), 2'b10 `opa_i` signed and `opb_i` unsigned. 2'b11 behaves as 2'b00.
- R2: In integer form, `prod_o` is the low 16 bits of the exact product of the operands, read as R1 specifies.
- R3: In fractional form, `prod_o` is that integer product shifted left by one bit, with bit 0 zero. Both signed 0x80 × 0x80 gives 0x8000.
- R4: `flag_c_o` equals bit 15 of the integer product, taken before any fractional shift.
- R5: `flag_z_o` is 1 exactly when the final 16-bit `prod_o` is zero.
- R6: A start sampled at clock edge k makes `done_o` high for exactly the one cycle after edge k+1. `prod_o` and the flags are valid in that cycle and hold until the next completion.
- R7: `busy_o` is high for the one cycle between edge k and edge k+1. A start sampled while `busy_o` is high is ignored: it neither alters the pending result nor produces another done.
- R8: `dest_hi_o` is always 1 and `dest_lo_o` is always 0. They name the high and low registers that receive the product.
- R9: After a synchronous active-low reset, `busy_o`, `done_o`, `prod_o`, `flag_z_o` and `flag_c_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only when idle |
| mode_i | input | 3 | Bit 2 fractional, bits 1:0 signedness |
| opa_i | input | 8 | First operand |
| opb_i | input | 8 | Second operand |
| busy_o | output | 1 | Operation in flight |
| done_o | output | 1 | One-cycle completion pulse |
| prod_o | output | 16 | Product result |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry flag |
| dest_hi_o | output | 5 | Index of the register that takes the high byte |
| dest_lo_o | output | 5 | Index of the register that takes the low byte |

## Verification
`busy_o` is due one edge after an accepted start, and `done_o`, `prod_o` and both flags are due one edge later. Every stimulus is applied on a falling edge. The bench then checks busy at the next falling edge and the result at the falling edge after that, which keeps each sample half a period away from the edge that updates it. One further falling edge confirms that done has dropped. The test that restarts while busy uses that same sampling point to show that the second strobe left neither a result change nor an extra done.

// File: rtl/fmul_pkg.sv
// Package: shared widths and the signedness selector for the multiplier.
// Assumes operands are bytes; products are twice that width.
package fmul_pkg;
    localparam int OP_W   = 8;
    localparam int IDX_W  = 5;

    typedef enum logic [1:0] {
        SGN_UU  = 2'b00,
        SGN_SS  = 2'b01,
        SGN_SU  = 2'b10,
        SGN_RSV = 2'b11
    } sgn_mode_e;
endpackage

// File: rtl/fmul_ext.sv
// Module: widens one operand by one bit, sign-extending when it is to be
// read as two's complement and zero-extending otherwise.
// Assumes the caller decides signedness per operand.
module fmul_ext #(
    parameter int W = 8
) (
    input  logic [W-1:0]        val_i,
    input  logic                is_signed_i,
    output logic signed [W:0]   ext_o
);
    // Choose the extension bit from the operand MSB or zero.
    always_comb begin
        ext_o = {is_signed_i & val_i[W-1], val_i};
    end
endmodule

// File: rtl/fmul_core.sv
// Module: combinational multiply with per-operand signedness, optional
// fractional left shift, and carry/zero flag generation.
// Assumes operands were already latched; output is used one edge later.
module fmul_core
    import fmul_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]     a_i,
    input  logic [W-1:0]     b_i,
    input  sgn_mode_e        sgn_i,
    input  logic             frac_i,
    output logic [2*W-1:0]   prod_o,
    output logic             c_o,
    output logic             z_o
);
    localparam int PW = 2 * W;

    logic               a_sgn;
    logic               b_sgn;
    logic signed [W:0]  a_ext;
    logic signed [W:0]  b_ext;
    logic signed [2*W+1:0] full;
    logic [PW-1:0]      raw;

    // Decode which operands are two's complement for this mode.
    always_comb begin
        a_sgn = (sgn_i == SGN_SS) || (sgn_i == SGN_SU);
        b_sgn = (sgn_i == SGN_SS);
    end

    // One extender per operand, built from a generate loop.
    for (genvar g = 0; g < 2; g++) begin : g_ext
        if (g == 0) begin : g_a
            fmul_ext #(.W(W)) u_ext (.val_i(a_i), .is_signed_i(a_sgn), .ext_o(a_ext));
        end else begin : g_b
            fmul_ext #(.W(W)) u_ext (.val_i(b_i), .is_signed_i(b_sgn), .ext_o(b_ext));
        end
    end

    // Multiply the widened operands and keep the low product bits.
    always_comb begin
        full = (2*W+2)'(a_ext) * (2*W+2)'(b_ext);
        raw  = full[PW-1:0];
    end

    // Apply the fractional shift and derive the flags.
    always_comb begin
        prod_o = frac_i ? {raw[PW-2:0], 1'b0} : raw;
        c_o    = raw[PW-1];
        z_o    = (prod_o == '0);
    end
endmodule

// File: rtl/fmul_ctrl.sv
// Module: two-cycle sequencer. Accepts a start when idle, holds busy for
// one cycle, then pulses done for one cycle.
// Assumes start is a level sampled at each rising edge.
module fmul_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic accept_o,
    output logic busy_o,
    output logic done_o
);
    // Accept a start only while idle.
    always_comb begin
        accept_o = start_i && !busy_o;
    end

    // Advance busy and done each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            done_o <= 1'b0;
        end else begin
            busy_o <= accept_o;
            done_o <= busy_o;
        end
    end

    a_r6_done_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (done_o && !busy_o));
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> !busy_o);
endmodule

// File: rtl/frac_mul_unit.sv
// Module: top of the two-cycle 8x8 multiplier. Latches operands and mode on
// an accepted start, computes on the following edge and registers product
// and flags together with the done pulse. Product targets a fixed pair.
// Assumes synchronous active-low reset.
module frac_mul_unit
    import fmul_pkg::*;
#(
    parameter int W         = OP_W,
    parameter int IW        = IDX_W,
    parameter int DEST_HI   = 1,
    parameter int DEST_LO   = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [2:0]      mode_i,
    input  logic [W-1:0]    opa_i,
    input  logic [W-1:0]    opb_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [2*W-1:0]  prod_o,
    output logic            flag_z_o,
    output logic            flag_c_o,
    output logic [IW-1:0]   dest_hi_o,
    output logic [IW-1:0]   dest_lo_o
);
    localparam int PW = 2 * W;

    logic           accept;
    logic [W-1:0]   a_q;
    logic [W-1:0]   b_q;
    sgn_mode_e      sgn_q;
    logic           frac_q;
    logic [PW-1:0]  core_prod;
    logic           core_c;
    logic           core_z;

    fmul_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .accept_o (accept),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    // Latch operands and mode when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            sgn_q  <= SGN_UU;
            frac_q <= 1'b0;
        end else if (accept) begin
            a_q    <= opa_i;
            b_q    <= opb_i;
            sgn_q  <= sgn_mode_e'(mode_i[1:0]);
            frac_q <= mode_i[2];
        end
    end

    fmul_core #(.W(W)) u_core (
        .a_i    (a_q),
        .b_i    (b_q),
        .sgn_i  (sgn_q),
        .frac_i (frac_q),
        .prod_o (core_prod),
        .c_o    (core_c),
        .z_o    (core_z)
    );

    // Register product and flags on the second edge of an operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_o   <= '0;
            flag_c_o <= 1'b0;
            flag_z_o <= 1'b0;
        end else if (busy_o) begin
            prod_o   <= core_prod;
            flag_c_o <= core_c;
            flag_z_o <= core_z;
        end
    end

    // Report the fixed destination pair.
    always_comb begin
        dest_hi_o = IW'(DEST_HI);
        dest_lo_o = IW'(DEST_LO);
    end

    a_r5_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (flag_z_o == (prod_o == '0)));
    a_r3_frac_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && frac_q) |=> (prod_o[0] == 1'b0));
    a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && rst_n) |=> $stable(prod_o));
endmodule

// File: tb/frac_mul_unit_bench.sv
module frac_mul_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  mode_i = '0;
    logic [7:0]  opa_i = '0;
    logic [7:0]  opb_i = '0;
    logic        busy_o;
    logic        done_o;
    logic [15:0] prod_o;
    logic        flag_z_o;
    logic        flag_c_o;
    logic [4:0]  dest_hi_o;
    logic [4:0]  dest_lo_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    frac_mul_unit u_frac_mul_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .opa_i(opa_i), .opb_i(opb_i), .busy_o(busy_o), .done_o(done_o),
        .prod_o(prod_o), .flag_z_o(flag_z_o), .flag_c_o(flag_c_o),
        .dest_hi_o(dest_hi_o), .dest_lo_o(dest_lo_o)
    );

    // {mode, a, b, product, c, z}
    localparam int NV = 12;
    localparam logic [36:0] VEC [NV] = '{
        {3'b000, 8'hFF, 8'hFF, 16'hFE01, 1'b1, 1'b0},  // R2 UU
        {3'b001, 8'hFF, 8'hFF, 16'h0001, 1'b0, 1'b0},  // R2 SS
        {3'b010, 8'hFF, 8'h02, 16'hFFFE, 1'b1, 1'b0},  // R2 SU
        {3'b100, 8'h80, 8'h80, 16'h8000, 1'b0, 1'b0},  // R3 UU frac
        {3'b101, 8'h80, 8'h80, 16'h8000, 1'b0, 1'b0},  // R3 -1.0*-1.0 wrap
        {3'b001, 8'h80, 8'h7F, 16'hC080, 1'b1, 1'b0},  // R4 SS negative
        {3'b110, 8'h80, 8'hFF, 16'h0100, 1'b1, 1'b0},  // R4 SU frac, C pre-shift
        {3'b000, 8'h00, 8'h5A, 16'h0000, 1'b0, 1'b1},  // R5 zero
        {3'b100, 8'hFF, 8'hFF, 16'hFC02, 1'b1, 1'b0},  // R3 UU frac
        {3'b010, 8'h7F, 8'hFF, 16'h7E81, 1'b0, 1'b0},  // R1 SU positive a
        {3'b011, 8'hFF, 8'h02, 16'h01FE, 1'b0, 1'b0},  // R1 reserved as UU
        {3'b101, 8'h40, 8'h40, 16'h2000, 1'b0, 1'b0}   // R3 0.5*0.5
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    // Launch one operation at a falling edge; leaves clock at falling edge
    // of the busy cycle.
    task automatic launch(input logic [2:0] m, input logic [7:0] a, input logic [7:0] b);
        mode_i  = m;
        opa_i   = a;
        opb_i   = b;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual expired expected finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9", "busy", busy_o, 0);
        check("R9", "done", done_o, 0);
        check("R9", "prod", prod_o, 0);
        check("R9", "flags", {flag_z_o, flag_c_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 destination pair
        check("R8", "dest_hi", dest_hi_o, 1);
        check("R8", "dest_lo", dest_lo_o, 0);

        for (int i = 0; i < NV; i++) begin
            launch(VEC[i][36:34], VEC[i][33:26], VEC[i][25:18]);
            check("R7", "busy mid-op", {busy_o, done_o}, 2'b10);
            @(negedge clk);
            check("R6", "done", {busy_o, done_o}, 2'b01);
            check("R2", "prod", prod_o, VEC[i][17:2]);
            check("R4", "carry", flag_c_o, VEC[i][1]);
            check("R5", "zero", flag_z_o, VEC[i][0]);
            @(negedge clk);
            check("R6", "done dropped", done_o, 0);
        end

        // R6 hold: result stays after done
        repeat (2) @(negedge clk);
        check("R6", "hold", prod_o, 16'h2000);

        // R7 start while busy ignored
        launch(3'b000, 8'h03, 8'h05);
        mode_i = 3'b001; opa_i = 8'h80; opb_i = 8'h80; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R7", "first result kept", prod_o, 16'h000F);
        check("R7", "done", done_o, 1);
        @(negedge clk);
        check("R7", "no second op", {busy_o, done_o}, 2'b00);
        @(negedge clk);
        check("R7", "no second done", {done_o, prod_o}, {1'b0, 16'h000F});

        // R9 reset mid-operation clears everything
        launch(3'b000, 8'hFF, 8'hFF);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9", "reset clears", {busy_o, done_o, prod_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule